// File: doc/BRIEF.md
# PCM Interrupt Status and Enable Unit

This unit gathers the interrupt-worthy conditions of a serial audio port into one status word. It covers receive and transmit FIFO conditions and a per-word transfer event. Each condition has an enable bit. The unit forms a pending flag from every enabled condition that is present. A master enable bit then gates that flag onto a single interrupt line.

Condition sources come in two kinds. Error and transfer events (overflow, starvation, word transfer) arrive as one-cycle pulses and are held until software clears them. FIFO level conditions (almost-full, full, almost-empty, empty) are re-sampled from the live FIFO flags on every clock. Software programs the enables with a write strobe and data word. It removes held events by writing ones to a clear strobe and data word.

Top module: `pcm_irq_unit`

## Requirements
- R1: After reset the status word, the enable word, `pending` and `irq` are all zero.
- R2: Status bit `b` (0..12) is driven by `event_src[b]`. The layout is: 0 receive overflow, 1 receive starve, 2 receive almost-full, 3 receive full, 4 receive almost-empty, 5 receive empty. Bits 6..11 hold the same six conditions for transmit, in the same order. Bit 12 is word transfer. Enable bit `b` masks status bit `b`.
- R3: Held bits (0, 1, 6, 7, 12) become 1 on the clock edge at which their source is 1. They stay 1 until cleared.
- R4: Level bits (2..5, 8..11) show the value their source had at the previous clock edge. A clear write has no effect on them.
- R5: A clock edge with `clr_wr`=1 clears every held bit whose `clr_wdata` bit is 1. Held bits whose clear bit is 0 are left unchanged.
- R6: When a held bit's source is 1 at the same edge that clears it, the bit is 1 after that edge.
- R7: `pending`, which is also status bit 13, is 1 exactly when some status bit 0..12 and its enable bit are both 1. It follows the registers without added delay.
- R8: `irq` equals `pending` AND enable bit 14, the master enable.
- R9: A clock edge with `en_wr`=1 loads `en_wdata` into the enable word. Bits 13 and 15 and above always read 0.
- R10: `clr_wdata` has no effect while `clr_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_src | input | 13 | Condition sources in status bit order |
| en_wr | input | 1 | Enable word write strobe |
| en_wdata | input | REG_W | Enable word write data |
| clr_wr | input | 1 | Clear write strobe |
| clr_wdata | input | REG_W | Clear mask, one bit per status bit |
| en_q | output | REG_W | Enable word readback |
| status_q | output | REG_W | Status word with pending at bit 13 |
| pending | output | 1 | Any enabled condition present |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the unit with `REG_W`=16 and the default held-bit mask. A 16-bit register has bit 15 above the master enable, so writes with all ones show that reserved upper and pending positions read back as zero. With the default mask, all five held sources and all eight level sources are reached by random pulses and flags. The random phase sometimes drives a clear and a fresh pulse on the same bit in the same cycle. It also raises the clear data without its strobe.

// File: rtl/pcm_irq_pkg.sv
package pcm_irq_pkg;
   // Number of condition sources; status bits 0..EV_COUNT-1
   localparam int EV_COUNT   = 13;
   // Aggregated pending flag in the status word
   localparam int PEND_BIT   = 13;
   // Master interrupt enable in the enable word
   localparam int MASTER_BIT = 14;
   // Narrowest register that holds every defined bit
   localparam int MIN_REG_W  = MASTER_BIT + 1;
   // Held (sticky) sources: overflow and starve of each direction, word transfer
   localparam logic [EV_COUNT-1:0] DEF_STICKY = 13'b1_0000_1100_0011;
endpackage

// File: rtl/pcm_irq_status_bit.sv
module pcm_irq_status_bit #(
   parameter bit STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_i,
   input  logic clr_i,
   output logic q_o
);
   logic keep;

   // A held bit retains its value unless cleared; a level bit never retains.
   // The new event always ORs in, so it wins over a clear in the same cycle.
   assign keep = STICKY ? ~clr_i : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= ev_i | (q_o & keep);
   end
endmodule

// File: rtl/pcm_irq_enable_reg.sv
module pcm_irq_enable_reg
   import pcm_irq_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] q_o
);
   // Implemented enable bits: one per source plus the master bit
   localparam logic [REG_W-1:0] IMPL_MASK =
      REG_W'((64'd1 << EV_COUNT) - 64'd1) | (REG_W'(1) << MASTER_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (wr_i) q_o <= wdata_i & IMPL_MASK;
   end
endmodule

// File: rtl/pcm_irq_combine.sv
module pcm_irq_combine
   import pcm_irq_pkg::*;
#(
   parameter bit TREE_REDUCE = 1'b1
) (
   input  logic [EV_COUNT-1:0] status_i,
   input  logic [EV_COUNT-1:0] enable_i,
   input  logic                master_i,
   output logic                pending_o,
   output logic                irq_o
);
   logic [EV_COUNT-1:0] hit;
   assign hit = status_i & enable_i;

   if (TREE_REDUCE) begin : g_tree
      assign pending_o = |hit;
   end else begin : g_chain
      logic [EV_COUNT:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < EV_COUNT; i++) begin : g_link
         assign acc[i+1] = acc[i] | hit[i];
      end
      assign pending_o = acc[EV_COUNT];
   end

   assign irq_o = pending_o & master_i;
endmodule

// File: rtl/pcm_irq_unit.sv
module pcm_irq_unit
   import pcm_irq_pkg::*;
#(
   parameter int                  REG_W       = 16,
   parameter logic [EV_COUNT-1:0] STICKY_MASK = DEF_STICKY,
   parameter bit                  TREE_REDUCE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [EV_COUNT-1:0] event_src,
   input  logic                en_wr,
   input  logic [REG_W-1:0]    en_wdata,
   input  logic                clr_wr,
   input  logic [REG_W-1:0]    clr_wdata,
   output logic [REG_W-1:0]    en_q,
   output logic [REG_W-1:0]    status_q,
   output logic                pending,
   output logic                irq
);
   if (REG_W < MIN_REG_W) begin : g_bad_width
      $error("pcm_irq_unit: REG_W must be at least %0d", MIN_REG_W);
   end
   if (REG_W > 64) begin : g_bad_wide
      $error("pcm_irq_unit: REG_W must not exceed 64");
   end

   logic [EV_COUNT-1:0] st;
   logic                unused_clr_hi;

   assign unused_clr_hi = &{1'b0, clr_wdata[REG_W-1:EV_COUNT]};

   for (genvar b = 0; b < EV_COUNT; b++) begin : g_bit
      pcm_irq_status_bit #(.STICKY(STICKY_MASK[b])) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .ev_i  (event_src[b]),
         .clr_i (clr_wr & clr_wdata[b]),
         .q_o   (st[b])
      );
   end

   pcm_irq_enable_reg #(.REG_W(REG_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (en_wr),
      .wdata_i (en_wdata),
      .q_o     (en_q)
   );

   pcm_irq_combine #(.TREE_REDUCE(TREE_REDUCE)) u_comb (
      .status_i  (st),
      .enable_i  (en_q[EV_COUNT-1:0]),
      .master_i  (en_q[MASTER_BIT]),
      .pending_o (pending),
      .irq_o     (irq)
   );

   always_comb begin
      status_q               = '0;
      status_q[EV_COUNT-1:0] = st;
      status_q[PEND_BIT]     = pending;
   end
endmodule

// File: rtl/pcm_irq_unit_chk.sv
module pcm_irq_unit_chk
   import pcm_irq_pkg::*;
#(
   parameter int                  REG_W       = 16,
   parameter logic [EV_COUNT-1:0] STICKY_MASK = DEF_STICKY
) (
   input logic                clk,
   input logic                rst_n,
   input logic [EV_COUNT-1:0] event_src,
   input logic                en_wr,
   input logic [REG_W-1:0]    en_wdata,
   input logic                clr_wr,
   input logic [REG_W-1:0]    clr_wdata,
   input logic [REG_W-1:0]    en_q,
   input logic [REG_W-1:0]    status_q,
   input logic                pending,
   input logic                irq
);
   localparam logic [REG_W-1:0] IMPL =
      REG_W'((64'd1 << EV_COUNT) - 64'd1) | (REG_W'(1) << MASTER_BIT);

   for (genvar b = 0; b < EV_COUNT; b++) begin : g_chk
      if (STICKY_MASK[b]) begin : g_held
         // R3: a held bit set and not cleared stays set
         assert_held_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[b] && !(clr_wr && clr_wdata[b])) |=> status_q[b]);
         // R6: a source pulse sets the bit even against a clear
         assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            event_src[b] |=> status_q[b]);
         // R5: clear without a new event empties the bit
         assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_wdata[b] && !event_src[b]) |=> !status_q[b]);
      end else begin : g_level
         // R4: a level bit follows its source one edge later
         assert_level_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            event_src[b] |=> status_q[b]);
         assert_level_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !event_src[b] |=> !status_q[b]);
      end
   end

   // R7: nothing enabled and present means no pending
   assert_no_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q[EV_COUNT-1:0] & en_q[EV_COUNT-1:0]) == '0) |-> !pending);
   // R8: interrupt line only with pending and master enable
   assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status_q[PEND_BIT] && en_q[MASTER_BIT]));
   // R9: enable write loads implemented bits only
   assert_en_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (en_q == ($past(en_wdata) & IMPL)));
   // R10: no strobe, no change to held bits set beforehand
   assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && ((status_q[EV_COUNT-1:0] & STICKY_MASK) != '0))
      |=> ((status_q[EV_COUNT-1:0] & $past(status_q[EV_COUNT-1:0]) & STICKY_MASK)
           == ($past(status_q[EV_COUNT-1:0]) & STICKY_MASK)));
endmodule

bind pcm_irq_unit pcm_irq_unit_chk #(
   .REG_W       (REG_W),
   .STICKY_MASK (STICKY_MASK)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .event_src (event_src),
   .en_wr     (en_wr),
   .en_wdata  (en_wdata),
   .clr_wr    (clr_wr),
   .clr_wdata (clr_wdata),
   .en_q      (en_q),
   .status_q  (status_q),
   .pending   (pending),
   .irq       (irq)
);

// File: tb/pcm_irq_unit_tb.sv
module pcm_irq_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int NEV        = 13;
   localparam logic [NEV-1:0] HELD = 13'h10C3;   // bits 0,1,6,7,12
   localparam logic [W-1:0]   ENM  = 16'h5FFF;   // bits 0..12 and 14

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NEV-1:0] event_src = '0;
   logic           en_wr = 1'b0;
   logic [W-1:0]   en_wdata = '0;
   logic           clr_wr = 1'b0;
   logic [W-1:0]   clr_wdata = '0;
   logic [W-1:0]   en_q, status_q;
   logic           pending, irq;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   logic [NEV-1:0] m_st = '0;
   logic [W-1:0]   m_en = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_irq_unit #(.REG_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .event_src(event_src),
      .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
      .en_q(en_q), .status_q(status_q), .pending(pending), .irq(irq)
   );

   function automatic logic exp_pend(input logic [NEV-1:0] s, input logic [W-1:0] e);
      return |(s & e[NEV-1:0]);
   endfunction

   function automatic logic [W-1:0] exp_status(input logic [NEV-1:0] s, input logic [W-1:0] e);
      logic [W-1:0] r;
      r = '0;
      r[NEV-1:0] = s;
      r[13] = exp_pend(s, e);
      return r;
   endfunction

   function automatic logic [NEV-1:0] next_st(input logic [NEV-1:0] s, input logic [NEV-1:0] ev,
                                              input logic cw, input logic [W-1:0] cd);
      logic [NEV-1:0] keep;
      keep = HELD & ~(cw ? cd[NEV-1:0] : '0);
      return ev | (s & keep);
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string phase);
      logic [W-1:0] es;
      es = exp_status(m_st, m_en);
      check(status_q === es, {phase, " R2 R3 R4 R5 R6 R10 status"}, 32'(status_q), 32'(es));
      check(en_q === m_en, {phase, " R9 enable"}, 32'(en_q), 32'(m_en));
      check(pending === exp_pend(m_st, m_en), {phase, " R7 pending"}, 32'(pending), 32'(exp_pend(m_st, m_en)));
      check(irq === (exp_pend(m_st, m_en) & m_en[14]), {phase, " R8 irq"}, 32'(irq),
            32'(exp_pend(m_st, m_en) & m_en[14]));
   endtask

   // one cycle: model updates at the edge from held inputs, check at the falling edge
   task automatic step(input string phase);
      @(posedge clk);
      m_st = next_st(m_st, event_src, clr_wr, clr_wdata);
      if (en_wr) m_en = en_wdata & ENM;
      @(negedge clk);
      check_all(phase);
   endtask

   task automatic drive(input logic [NEV-1:0] ev, input logic ew, input logic [W-1:0] ed,
                        input logic cw, input logic [W-1:0] cd);
      event_src = ev; en_wr = ew; en_wdata = ed; clr_wr = cw; clr_wdata = cd;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin : stim
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      // R1: reset state, with sources active during reset
      event_src = '1;
      @(negedge clk);
      check(status_q === '0 && en_q === '0, "R1 reset regs", 32'({status_q, en_q}), 32'd0);
      check(irq === 1'b0 && pending === 1'b0, "R1 reset irq", 32'({irq, pending}), 32'd0);
      drive('0, 1'b0, '0, 1'b0, '0);
      rst_n = 1'b1;

      // R9: all ones into enable, reserved bits drop
      drive('0, 1'b1, 16'hFFFF, 1'b0, '0);
      step("R9 enable_all");
      // R3: receive overflow pulse then hold
      drive(13'h0001, 1'b0, '0, 1'b0, '0);
      step("R3 pulse");
      drive('0, 1'b0, '0, 1'b0, '0);
      step("R3 hold1");
      step("R3 hold2");
      // R6: clear and new event together
      drive(13'h0001, 1'b0, '0, 1'b1, 16'h0001);
      step("R6 event_wins");
      // R10: clear data without strobe
      drive('0, 1'b0, '0, 1'b0, 16'hFFFF);
      step("R10 no_strobe");
      // R5: real clear
      drive('0, 1'b0, '0, 1'b1, 16'h0001);
      step("R5 clear");
      // R4: level bit ignores clear
      drive(13'h0008, 1'b0, '0, 1'b0, '0);
      step("R4 level_set");
      drive(13'h0008, 1'b0, '0, 1'b1, 16'hFFFF);
      step("R4 level_clear_ignored");
      // R8: master off keeps irq low while pending
      drive(13'h0008, 1'b1, 16'h1FFF, 1'b0, '0);
      step("R8 master_off");
      // R7: disable the present bit removes pending
      drive(13'h1008, 1'b1, 16'h4000, 1'b0, '0);
      step("R7 masked");
      drive('0, 1'b1, 16'h5FFF, 1'b1, 16'hFFFF);
      step("R7 R8 restore");

      // constrained random phase
      for (int i = 0; i < 3000; i++) begin
         logic [NEV-1:0] ev;
         ev = NEV'($urandom) & ~HELD;
         for (int b = 0; b < NEV; b++)
            if (HELD[b] && ($urandom % 8 == 0)) ev[b] = 1'b1;
         drive(ev, ($urandom % 16 == 0), W'($urandom), ($urandom % 4 == 0), W'($urandom));
         step("random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule